// File: doc/BRIEF.md
# Jump-Table Waveform Address Sequencer

This block produces a read address for a waveform memory, one address per clock, and decides where the address goes next from a small program held in a jump table. Each table entry names a trigger address, a continuation address and a 16-bit opcode. The address counts up by one each clock. When it reaches the trigger address of the entry that is currently active, the block runs that entry's opcode and then continues from the entry's continuation address. Only the END opcode breaks this rule.

The opcodes can hold the address for a number of clocks, loop a body a programmed number of times on one of several counters, branch on one bit of an external chain input, jump to another entry, pass straight on, or stop playback. Unless an opcode names a new entry, the active entry then moves on to the next index. Software-side parsing is out of scope. The table, the loop limits and the start address arrive as parsed fields on simple write ports. A start strobe clears the loop state, selects entry 0 and launches playback from the start address.

Top module: `jumptab_seq`

## Requirements
- R1: While reset is asserted and after it is released, `valid_o` and `done_o` are 0 and `addr_o` is 0.
- R2: One clock after `start` is sampled high, `addr_o` equals the sampled `start_addr`, `valid_o` is 1 and `done_o` is 0. Entry 0 is active and every loop count is cleared, so replaying the same table gives the same address trace.
- R3: While playing, if the address does not equal the active entry's trigger address, the next address is the current address plus one.
- R4: Opcode bit 0 = 0 is HOLD with N = opcode[15:1]. The trigger address stays on `addr_o` for N+1 clocks in total, then the continuation address follows. The active index advances by one.
- R5: Opcode low nibble 0101 is PASS. The continuation address follows on the next clock and the active index advances by one.
- R6: Opcode low nibble 1101 is JUMP. The continuation address follows and the active index becomes opcode[13:8].
- R7: Opcode low bits 001 is TEST. Bit opcode[7:4] of `chain_in` is compared with opcode[3]. On a match the active index becomes opcode[13:8]; otherwise it advances by one. The continuation address follows in both cases.
- R8: Opcode low bits 011 is LOOP on counter opcode[5:4], and the continuation address always follows. With limit L loaded for that counter, the first max(L,1)-1 executions set the active index to opcode[13:8]. The next execution finishes the loop: it clears that counter and advances the index by one. Other counters' limits have no effect.
- R9: Opcode low bits 111 is STOP. On the clock after the trigger address is shown, `valid_o` falls and `done_o` rises, and both hold with `addr_o` frozen until the next `start`.
- R10: A `start` while playing abandons the run and restarts as in R2.
- R11: Only the active entry's trigger address is compared; addresses matching other entries pass by as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ent_we | input | 1 | Write one table entry |
| ent_idx | input | IDX_W (6) | Entry index being written |
| ent_from | input | ADDR_W (24) | Trigger address of the entry |
| ent_to | input | ADDR_W (24) | Continuation address of the entry |
| ent_op | input | 16 | Opcode of the entry |
| lim_we | input | 1 | Write one loop limit |
| lim_sel | input | SEL_W (2) | Loop counter being written |
| lim_val | input | CNT_W (32) | Loop limit value |
| start | input | 1 | Start strobe |
| start_addr | input | ADDR_W (24) | Address playback begins from |
| chain_in | input | CHAIN_W (16) | External chain bits tested by TEST |
| addr_o | output | ADDR_W (24) | Memory read address |
| valid_o | output | 1 | Playback running, `addr_o` meaningful |
| done_o | output | 1 | Playback ended by STOP |

## Verification
All results come from registers one clock after the input that causes them. The start address shows one clock after the strobe. Every step, jump or branch shows one clock after the trigger address is shown, a HOLD of N keeps the trigger address for N+1 clocks, and `valid_o`/`done_o` change one clock after a STOP trigger. The bench drives inputs and samples outputs on the falling edge. It records one address per falling edge while `valid_o` is high and compares the whole trace with a trace it builds arithmetically from the loaded table. Sweeps cover every hold length from 0 to 5, every chain bit with both polarities under two bit patterns, and every loop counter with limits 0 to 4, each run twice to show that loop counts are cleared.

// File: rtl/jumptab_pkg.sv
package jumptab_pkg;
   localparam int OP_W = 16;

   typedef enum logic [2:0] {
      K_HOLD, K_TEST, K_LOOP, K_PASS, K_JUMP, K_STOP
   } op_kind_e;

   typedef struct packed {
      op_kind_e    kind;
      logic [14:0] hold_n;
      logic [3:0]  bit_sel;
      logic        pol;
      logic [1:0]  cnt_sel;
      logic [5:0]  tgt;
   } op_dec_t;
endpackage

// File: rtl/jumptab_decode.sv
module jumptab_decode
   import jumptab_pkg::*;
(
   input  logic [OP_W-1:0] op,
   output op_dec_t         dec
);
   always_comb begin
      dec.hold_n  = op[15:1];
      dec.bit_sel = op[7:4];
      dec.pol     = op[3];
      dec.cnt_sel = op[5:4];
      dec.tgt     = op[13:8];
      if (!op[0]) dec.kind = K_HOLD;
      else begin
         unique case (op[2:1])
            2'b00:   dec.kind = K_TEST;
            2'b01:   dec.kind = K_LOOP;
            2'b10:   dec.kind = op[3] ? K_JUMP : K_PASS;
            default: dec.kind = K_STOP;
         endcase
      end
   end
endmodule

// File: rtl/jumptab_table.sv
module jumptab_table #(
   parameter int ADDR_W = 24,
   parameter int N_ENT  = 64,
   parameter int OP_W   = 16,
   localparam int IDX_W = $clog2(N_ENT)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [IDX_W-1:0]  widx,
   input  logic [ADDR_W-1:0] wfrom,
   input  logic [ADDR_W-1:0] wto,
   input  logic [OP_W-1:0]   wop,
   input  logic [IDX_W-1:0]  ridx,
   output logic [ADDR_W-1:0] rfrom,
   output logic [ADDR_W-1:0] rto,
   output logic [OP_W-1:0]   rop
);
   logic [ADDR_W-1:0] from_m [N_ENT];
   logic [ADDR_W-1:0] to_m   [N_ENT];
   logic [OP_W-1:0]   op_m   [N_ENT];

   always_ff @(posedge clk) begin
      if (we) begin
         from_m[widx] <= wfrom;
         to_m[widx]   <= wto;
         op_m[widx]   <= wop;
      end
   end

   assign rfrom = from_m[ridx];
   assign rto   = to_m[ridx];
   assign rop   = op_m[ridx];
endmodule

// File: rtl/jumptab_loops.sv
module jumptab_loops #(
   parameter int N_CNT = 4,
   parameter int CNT_W = 32,
   localparam int SEL_W = $clog2(N_CNT)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lim_we,
   input  logic [SEL_W-1:0] lim_sel,
   input  logic [CNT_W-1:0] lim_val,
   input  logic             clear,
   input  logic             step,
   input  logic [SEL_W-1:0] sel,
   output logic             fin
);
   logic [CNT_W-1:0] lim_q  [N_CNT];
   logic [CNT_W-1:0] iter_q [N_CNT];
   logic [N_CNT-1:0] fin_v;

   for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
      assign fin_v[g] = ({1'b0, iter_q[g]} + (CNT_W+1)'(1)) >= {1'b0, lim_q[g]};
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lim_q[g]  <= '0;
            iter_q[g] <= '0;
         end else begin
            if (lim_we && lim_sel == SEL_W'(g)) lim_q[g] <= lim_val;
            if (clear) iter_q[g] <= '0;
            else if (step && sel == SEL_W'(g))
               iter_q[g] <= fin_v[g] ? '0 : iter_q[g] + CNT_W'(1);
         end
      end
   end

   assign fin = fin_v[sel];
endmodule

// File: rtl/jumptab_seq.sv
module jumptab_seq
   import jumptab_pkg::*;
#(
   parameter int ADDR_W  = 24,
   parameter int N_ENT   = 64,
   parameter int N_CNT   = 4,
   parameter int CNT_W   = 32,
   parameter int CHAIN_W = 16,
   localparam int IDX_W  = $clog2(N_ENT),
   localparam int SEL_W  = $clog2(N_CNT),
   localparam int CB_W   = $clog2(CHAIN_W)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ent_we,
   input  logic [IDX_W-1:0]   ent_idx,
   input  logic [ADDR_W-1:0]  ent_from,
   input  logic [ADDR_W-1:0]  ent_to,
   input  logic [OP_W-1:0]    ent_op,
   input  logic               lim_we,
   input  logic [SEL_W-1:0]   lim_sel,
   input  logic [CNT_W-1:0]   lim_val,
   input  logic               start,
   input  logic [ADDR_W-1:0]  start_addr,
   input  logic [CHAIN_W-1:0] chain_in,
   output logic [ADDR_W-1:0]  addr_o,
   output logic               valid_o,
   output logic               done_o
);
   if (N_ENT < 2 || N_ENT > 64 || (1 << IDX_W) != N_ENT)
      $error("N_ENT must be a power of two from 2 to 64");
   if (N_CNT < 2 || N_CNT > 4 || (1 << SEL_W) != N_CNT)
      $error("N_CNT must be 2 or 4");
   if (CHAIN_W < 2 || CHAIN_W > 16 || (1 << CB_W) != CHAIN_W)
      $error("CHAIN_W must be a power of two from 2 to 16");
   if (ADDR_W < 2 || CNT_W < 1)
      $error("ADDR_W and CNT_W too small");

   logic              run_q, done_q;
   logic [ADDR_W-1:0] addr_q, hold_to_q;
   logic [IDX_W-1:0]  idx_q;
   logic [14:0]       hold_q;
   logic [ADDR_W-1:0] e_from, e_to;
   logic [OP_W-1:0]   e_op;
   op_dec_t           dec;
   logic              hit, hold_busy, loop_fin, loop_step, test_ok;
   logic [IDX_W-1:0]  tgt_idx, nxt_idx;

   jumptab_table #(.ADDR_W(ADDR_W), .N_ENT(N_ENT), .OP_W(OP_W)) u_table (
      .clk(clk), .we(ent_we), .widx(ent_idx), .wfrom(ent_from), .wto(ent_to),
      .wop(ent_op), .ridx(idx_q), .rfrom(e_from), .rto(e_to), .rop(e_op)
   );

   jumptab_decode u_dec (.op(e_op), .dec(dec));

   assign hold_busy = hold_q != '0;
   assign hit       = run_q && !hold_busy && addr_q == e_from;
   assign loop_step = hit && !start && dec.kind == K_LOOP;
   assign tgt_idx   = dec.tgt[IDX_W-1:0];
   assign nxt_idx   = idx_q + IDX_W'(1);
   assign test_ok   = chain_in[dec.bit_sel[CB_W-1:0]] == dec.pol;

   jumptab_loops #(.N_CNT(N_CNT), .CNT_W(CNT_W)) u_loops (
      .clk(clk), .rst_n(rst_n), .lim_we(lim_we), .lim_sel(lim_sel),
      .lim_val(lim_val), .clear(start), .step(loop_step),
      .sel(dec.cnt_sel[SEL_W-1:0]), .fin(loop_fin)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q     <= 1'b0;
         done_q    <= 1'b0;
         addr_q    <= '0;
         hold_to_q <= '0;
         idx_q     <= '0;
         hold_q    <= '0;
      end else if (start) begin
         run_q  <= 1'b1;
         done_q <= 1'b0;
         addr_q <= start_addr;
         idx_q  <= '0;
         hold_q <= '0;
      end else if (run_q) begin
         if (hold_busy) begin
            hold_q <= hold_q - 15'd1;
            if (hold_q == 15'd1) addr_q <= hold_to_q;
         end else if (hit) begin
            unique case (dec.kind)
               K_HOLD: begin
                  idx_q <= nxt_idx;
                  if (dec.hold_n == '0) addr_q <= e_to;
                  else begin
                     hold_q    <= dec.hold_n;
                     hold_to_q <= e_to;
                  end
               end
               K_TEST: begin
                  addr_q <= e_to;
                  idx_q  <= test_ok ? tgt_idx : nxt_idx;
               end
               K_LOOP: begin
                  addr_q <= e_to;
                  idx_q  <= loop_fin ? nxt_idx : tgt_idx;
               end
               K_JUMP: begin
                  addr_q <= e_to;
                  idx_q  <= tgt_idx;
               end
               K_STOP: begin
                  run_q  <= 1'b0;
                  done_q <= 1'b1;
               end
               default: begin
                  addr_q <= e_to;
                  idx_q  <= nxt_idx;
               end
            endcase
         end else begin
            addr_q <= addr_q + ADDR_W'(1);
         end
      end
   end

   assign addr_o  = addr_q;
   assign valid_o = run_q;
   assign done_o  = done_q;
endmodule

// File: rtl/jumptab_seq_chk.sv
module jumptab_seq_chk #(
   parameter int ADDR_W = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [ADDR_W-1:0] start_addr,
   input logic [ADDR_W-1:0] addr_o,
   input logic              valid_o,
   input logic              done_o,
   input logic              hit,
   input logic              hold_busy
);
   p_start_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (valid_o && !done_o && addr_o == $past(start_addr)));

   p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !start && !hit && !hold_busy) |=> addr_o == $past(addr_o) + ADDR_W'(1));

   p_stop_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !start) |=> (done_o && !valid_o && $stable(addr_o)));

   p_fall_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(valid_o) |-> done_o);

   p_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !(valid_o && done_o));
endmodule

bind jumptab_seq jumptab_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
   .addr_o(addr_o), .valid_o(valid_o), .done_o(done_o),
   .hit(hit), .hold_busy(hold_busy)
);

// File: tb/jumptab_seq_tb.sv
module jumptab_seq_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ent_we = 1'b0;
   logic [5:0]  ent_idx = '0;
   logic [23:0] ent_from = '0, ent_to = '0;
   logic [15:0] ent_op = '0;
   logic        lim_we = 1'b0;
   logic [1:0]  lim_sel = '0;
   logic [31:0] lim_val = '0;
   logic        start = 1'b0;
   logic [23:0] start_addr = '0;
   logic [15:0] chain_in = '0;
   logic [23:0] addr_o;
   logic        valid_o, done_o;

   int n_chk = 0, n_err = 0, n_exp = 0;
   logic [23:0] expq [512];
   logic [23:0] cap  [512];

   always #10 clk = ~clk;

   jumptab_seq u_dut (
      .clk(clk), .rst_n(rst_n), .ent_we(ent_we), .ent_idx(ent_idx),
      .ent_from(ent_from), .ent_to(ent_to), .ent_op(ent_op),
      .lim_we(lim_we), .lim_sel(lim_sel), .lim_val(lim_val),
      .start(start), .start_addr(start_addr), .chain_in(chain_in),
      .addr_o(addr_o), .valid_o(valid_o), .done_o(done_o)
   );

   function automatic logic [15:0] op_hold(int n);  return {15'(n), 1'b0}; endfunction
   function automatic logic [15:0] op_test(int t, int b, int p);
      return {2'b00, 6'(t), 4'(b), 1'(p), 3'b001};
   endfunction
   function automatic logic [15:0] op_loop(int t, int c);
      return {2'b00, 6'(t), 2'b00, 2'(c), 1'b0, 3'b011};
   endfunction
   function automatic logic [15:0] op_jump(int t); return {2'b00, 6'(t), 8'h0D}; endfunction
   localparam logic [15:0] OP_PASS = 16'h0005;
   localparam logic [15:0] OP_STOP = 16'h0007;

   task automatic chk(bit ok, string req, string what, longint act, longint exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic put(int idx, int fa, int ta, logic [15:0] op);
      ent_we = 1'b1; ent_idx = 6'(idx); ent_from = 24'(fa); ent_to = 24'(ta); ent_op = op;
      @(negedge clk);
      ent_we = 1'b0;
   endtask

   task automatic setlim(int c, int v);
      lim_we = 1'b1; lim_sel = 2'(c); lim_val = 32'(v);
      @(negedge clk);
      lim_we = 1'b0;
   endtask

   task automatic push(int a); expq[n_exp] = 24'(a); n_exp++; endtask
   task automatic span(int a, int b); for (int i = a; i <= b; i++) push(i); endtask

   task automatic play(int sa, string req, string tag);
      int n;
      bit same;
      start_addr = 24'(sa); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      n = 0;
      while (valid_o && n < 500) begin
         cap[n] = addr_o; n++;
         @(negedge clk);
      end
      chk(n == n_exp && done_o, req, {tag, " trace length"}, n, n_exp);
      same = 1'b1;
      for (int i = 0; i < n && i < n_exp; i++)
         if (same && cap[i] != expq[i]) begin
            same = 1'b0;
            chk(1'b0, req, $sformatf("%s addr[%0d]", tag, i), cap[i], expq[i]);
         end
      if (same) chk(1'b1, req, tag, 0, 0);
      n_exp = 0;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(!valid_o && !done_o && addr_o == 0, "R1", "in reset", {valid_o, done_o, addr_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!valid_o && !done_o && addr_o == 0, "R1", "after reset", {valid_o, done_o, addr_o}, 0);

      // R2/R3/R9 straight count then stop
      put(0, 'h13, 'h0, OP_STOP);
      span('h10, 'h13);
      play('h10, "R3", "count up");
      repeat (3) @(negedge clk);
      chk(done_o && !valid_o && addr_o == 'h13, "R9", "stop held",
          {done_o, valid_o, addr_o}, {2'b10, 24'h13});

      // R10 restart while running (entry 0 never hit from 0x70)
      start_addr = 24'h10; start = 1'b1; @(negedge clk); start = 1'b0;
      chk(valid_o && addr_o == 'h10, "R2", "start load", addr_o, 'h10);
      @(negedge clk);
      start_addr = 24'h70; start = 1'b1; @(negedge clk); start = 1'b0;
      chk(valid_o && !done_o && addr_o == 'h70, "R10", "restart", addr_o, 'h70);
      @(negedge clk);
      chk(addr_o == 'h71, "R10", "restart step", addr_o, 'h71);

      // R4 hold sweep
      for (int n = 0; n <= 5; n++) begin
         put(0, 'h22, 'h40, op_hold(n));
         put(1, 'h41, 'h0, OP_STOP);
         span('h20, 'h21);
         for (int k = 0; k <= n; k++) push('h22);
         span('h40, 'h41);
         play('h20, "R4", $sformatf("hold n=%0d", n));
      end

      // R5 pass and R11 only active entry compared
      put(0, 'h05, 'h01, OP_PASS);
      put(1, 'h03, 'h0, OP_STOP);
      span(0, 5); span(1, 3);
      play(0, "R11", "pass and inactive match");

      // R6 jump
      put(0, 'h02, 'h10, op_jump(5));
      put(1, 'h11, 'h0, OP_STOP);
      put(5, 'h12, 'h0, OP_STOP);
      span(0, 2); span('h10, 'h12);
      play(0, "R6", "jump");

      // R7 test sweep over bit, polarity and pattern
      put(1, 'h09, 'h0, OP_STOP);
      put(5, 'h0A, 'h0, OP_STOP);
      for (int pat = 0; pat < 2; pat++)
         for (int b = 0; b < 16; b++)
            for (int p = 0; p < 2; p++) begin
               chain_in = pat == 0 ? 16'hA5C3 : 16'h5A3C;
               put(0, 'h01, 'h08, op_test(5, b, p));
               span(0, 1); span(8, 9);
               if (int'(chain_in[b]) == p) push('h0A);
               play(0, "R7", $sformatf("test pat=%0d bit=%0d pol=%0d", pat, b, p));
            end

      // R8 loop sweep, twice each (R2 clears counts)
      for (int c = 0; c < 4; c++)
         for (int l = 0; l <= 4; l++) begin
            for (int o = 0; o < 4; o++) setlim(o, o == c ? l : 7);
            put(0, 'h05, 'h02, op_loop(0, c));
            put(1, 'h07, 'h0, OP_STOP);
            for (int r = 0; r < 2; r++) begin
               span(0, 5);
               for (int k = 0; k < (l < 1 ? 1 : l); k++) span(2, 5);
               span(6, 7);
               play(0, r == 0 ? "R8" : "R2", $sformatf("loop c=%0d L=%0d run%0d", c, l, r));
            end
         end

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule